// File: doc/BRIEF.md
# Round-Robin Banked Output Queue

This block is the buffer at one output of a switch whose outputs are grouped into channels. In each clock cycle (one time slot), up to `LANES` words arrive on parallel input lanes, each lane with its own valid bit. The valid words are packed together so that no gaps remain. They are then rotated onto `LANES` physical FIFO banks, starting at a running write pointer. No bank takes more than one write per slot, so no storage element has to run faster than the link.

A single reader takes at most one word per slot and visits the banks in the same cyclic order. The banks together therefore act as one first-in first-out queue. The output uses a ready/valid handshake with show-ahead data. The block reports its status through an empty flag, a full flag, a total occupancy count and a count of the words dropped in the current slot. Free space is judged from the occupancy at the start of the slot, so when the queue runs short the drops always come from the end of that slot's arrival order.

Top module: `rr_logical_fifo`

## Requirements
- R1: While `rst` is high on a clock edge, the queue is emptied and both bank pointers are cleared. After that edge, `empty`=1, `occupancy`=0 and `out_valid`=0.
- R2: Words leave in the order they were accepted. Across slots, earlier slots come first. Within a slot, lower lane index comes first, and lane i carries `in_data[i*DATA_W +: DATA_W]`.
- R3: A lane whose `in_valid` bit is 0 takes no position in the sequence, so any mix of idle and active lanes gives a gap-free output order.
- R4: `out_valid` is 1 exactly when `occupancy` is nonzero. `out_data` shows the oldest word, and at most one word is removed per cycle, on a cycle where both `out_valid` and `out_ready` are 1. While `out_valid`=1 and `out_ready`=0, `out_data` holds its value into the next cycle.
- R5: After each edge, `occupancy` equals its previous value plus the words accepted minus the word removed. `empty` is 1 exactly when `occupancy`=0, and `full` is 1 exactly when `occupancy`=LANES*DEPTH.
- R6: Let free = LANES*DEPTH − occupancy at the start of the slot. The first free valid arrivals in lane order are accepted and the rest are dropped. In the same cycle, `drop_cnt` shows the number of dropped words.
- R7: A word removed in a slot does not make room for that same slot's arrivals. Space is judged from the occupancy before the slot.
- R8: Asserting `rst` while the queue holds data discards all of that data. Words accepted afterwards come out as a fresh sequence.
- R9: Each bank gets at most one write per slot. The number of bank writes equals the number of accepted words, and every accepted word is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one time slot |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | LANES | One valid bit per arrival lane |
| in_data | input | LANES*DATA_W | Arrival words; lane i at bits i*DATA_W upward |
| out_ready | input | 1 | Link accepts the presented word |
| out_valid | output | 1 | A word is presented |
| out_data | output | DATA_W | Oldest queued word |
| empty | output | 1 | Queue holds no word |
| full | output | 1 | Queue holds LANES*DEPTH words |
| occupancy | output | clog2(LANES*DEPTH+1) | Total words held |
| drop_cnt | output | clog2(LANES+1) | Words dropped in the current slot |

## Verification
`drop_cnt` is combinational from the inputs and the registered occupancy. The bench therefore reads it one nanosecond after driving a slot's lanes on the falling edge, inside the same slot. `occupancy`, `empty`, `full` and `out_valid` change on the rising edge that ends a slot, so each is compared with the model at the next falling edge. The show-ahead `out_data` is compared with the scoreboard head in the same slot in which the handshake completes. A stall check compares it with the value seen one slot earlier.

// File: rtl/rrq_pkg.sv
package rrq_pkg;

   // Cyclic sum of two indices below n (operands each below n).
   function automatic int mod_add(input int a, input int b, input int n);
      int s;
      s = a + b;
      if (s >= n) s = s - n;
      return s;
   endfunction

   function automatic int min_int(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/rrq_rank.sv
// Packs the valid lanes: each lane learns how many valid lanes sit below it.
module rrq_rank #(
   parameter int LANES = 4,
   parameter int LW    = 2,
   parameter int VW    = 3
) (
   input  logic [LANES-1:0]         in_valid,
   output logic [LANES-1:0][LW-1:0] rank,
   output logic [VW-1:0]            nvalid
);

   always_comb begin
      int k;
      k = 0;
      for (int i = 0; i < LANES; i++) begin
         rank[i] = LW'(k);
         if (in_valid[i]) k = k + 1;
      end
      nvalid = VW'(k);
   end

endmodule

// File: rtl/rrq_bank.sv
// One physical bank: a plain circular FIFO with show-ahead head word.
// Overflow and underflow are excluded by the caller.
module rrq_bank #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] head
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_idx, rd_idx;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_idx <= '0;
         rd_idx <= '0;
      end else begin
         if (push) wr_idx <= step(wr_idx);
         if (pop)  rd_idx <= step(rd_idx);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_idx] <= wdata;
   end

   assign head = mem[rd_idx];

endmodule

// File: rtl/rr_logical_fifo.sv
module rr_logical_fifo #(
   parameter int  LANES  = 4,
   parameter int  DATA_W = 8,
   parameter int  DEPTH  = 4,
   localparam int CW     = $clog2(LANES * DEPTH + 1),
   localparam int VW     = $clog2(LANES + 1)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [LANES-1:0]          in_valid,
   input  logic [LANES*DATA_W-1:0]   in_data,
   input  logic                      out_ready,
   output logic                      out_valid,
   output logic [DATA_W-1:0]         out_data,
   output logic                      empty,
   output logic                      full,
   output logic [CW-1:0]             occupancy,
   output logic [VW-1:0]             drop_cnt
);

   localparam int  LW   = $clog2(LANES);
   localparam int  CAP  = LANES * DEPTH;
   localparam bit  POW2 = ((1 << LW) == LANES);

   // elaboration-time parameter checks
   if (LANES < 2) begin : g_bad_lanes
      $error("rr_logical_fifo: LANES must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("rr_logical_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rr_logical_fifo: DATA_W must be positive");
   end

   logic [LW-1:0]              wptr, rptr, wptr_nxt, rptr_inc;
   logic [CW-1:0]              count;
   logic [LANES-1:0][LW-1:0]   rank;
   logic [VW-1:0]              nvalid;
   logic [LANES-1:0]           acc_lane;
   logic [LANES-1:0][LW-1:0]   tgt;
   logic [VW-1:0]              n_acc;
   logic [LANES-1:0]           bank_push;
   logic [LANES-1:0]           bank_pop;
   logic [LANES-1:0][DATA_W-1:0] bank_wdata;
   logic [DATA_W-1:0]          bank_head [LANES];
   logic                       pop;

   // ---------------- compaction ----------------
   rrq_rank #(.LANES(LANES), .LW(LW), .VW(VW)) u_rank (
      .in_valid (in_valid),
      .rank     (rank),
      .nvalid   (nvalid)
   );

   // ---------------- admission ----------------
   always_comb begin
      int free_sp;
      int acc;
      free_sp = CAP - int'(count);
      acc     = rrq_pkg::min_int(int'(nvalid), free_sp);
      n_acc   = VW'(acc);
      for (int i = 0; i < LANES; i++) begin
         acc_lane[i] = in_valid[i] && (int'(rank[i]) < free_sp);
      end
   end

   assign drop_cnt = nvalid - n_acc;

   // ---------------- rotation onto banks ----------------
   if (POW2) begin : g_rot_pow2
      always_comb begin
         for (int i = 0; i < LANES; i++) tgt[i] = wptr + rank[i];
      end
      assign wptr_nxt = wptr + LW'(n_acc);
      assign rptr_inc = rptr + LW'(1);
   end else begin : g_rot_gen
      always_comb begin
         for (int i = 0; i < LANES; i++)
            tgt[i] = LW'(rrq_pkg::mod_add(int'(wptr), int'(rank[i]), LANES));
      end
      assign wptr_nxt = LW'(rrq_pkg::mod_add(int'(wptr), int'(n_acc) % LANES, LANES));
      assign rptr_inc = LW'(rrq_pkg::mod_add(int'(rptr), 1, LANES));
   end

   always_comb begin
      for (int b = 0; b < LANES; b++) begin
         bank_push[b]  = 1'b0;
         bank_wdata[b] = '0;
         for (int i = 0; i < LANES; i++) begin
            if (acc_lane[i] && (tgt[i] == LW'(b))) begin
               bank_push[b]  = 1'b1;
               bank_wdata[b] = in_data[i*DATA_W +: DATA_W];
            end
         end
      end
   end

   // ---------------- banks ----------------
   for (genvar b = 0; b < LANES; b++) begin : g_bank
      assign bank_pop[b] = pop && (rptr == LW'(b));
      rrq_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
         .clk   (clk),
         .rst   (rst),
         .push  (bank_push[b]),
         .wdata (bank_wdata[b]),
         .pop   (bank_pop[b]),
         .head  (bank_head[b])
      );
   end

   // ---------------- read side ----------------
   assign out_valid = (count != '0);
   assign pop       = out_valid && out_ready;
   assign out_data  = bank_head[rptr];

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         wptr  <= wptr_nxt;
         if (pop) rptr <= rptr_inc;
         count <= CW'(int'(count) + int'(n_acc) - int'(pop));
      end
   end

   assign empty     = (count == '0);
   assign full      = (count == CW'(CAP));
   assign occupancy = count;

endmodule

// File: rtl/rrq_checker.sv
module rrq_checker #(
   parameter int LANES  = 4,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   parameter int CW     = 5,
   parameter int VW     = 3
) (
   input logic              clk,
   input logic              rst,
   input logic [LANES-1:0]  in_valid,
   input logic              out_ready,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              empty,
   input logic              full,
   input logic [CW-1:0]     occupancy,
   input logic [VW-1:0]     drop_cnt,
   input logic [LANES-1:0]  bank_push
);

   localparam int CAP = LANES * DEPTH;

   assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (empty && occupancy == '0 && !out_valid));

   assert_stall_holds_R4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_empty_no_valid_R4: assert property (@(posedge clk) disable iff (rst)
      empty |-> !out_valid);

   assert_occupancy_update_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (int'(occupancy) == int'($past(occupancy))
                       + $countones($past(in_valid)) - int'($past(drop_cnt))
                       - int'($past(out_valid && out_ready))));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
      int'(occupancy) <= CAP);

   assert_drop_only_at_cap_R6: assert property (@(posedge clk) disable iff (rst)
      (drop_cnt != '0) |-> (int'(occupancy) + $countones(in_valid) - int'(drop_cnt) == CAP));

   assert_full_drops_all_R7: assert property (@(posedge clk) disable iff (rst)
      full |-> (int'(drop_cnt) == $countones(in_valid)));

   assert_bank_writes_R9: assert property (@(posedge clk) disable iff (rst)
      $countones(bank_push) == $countones(in_valid) - int'(drop_cnt));

endmodule

bind rr_logical_fifo rrq_checker #(
   .LANES(LANES), .DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW), .VW(VW)
) i_rrq_checker (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_ready (out_ready),
   .out_valid (out_valid),
   .out_data  (out_data),
   .empty     (empty),
   .full      (full),
   .occupancy (occupancy),
   .drop_cnt  (drop_cnt),
   .bank_push (bank_push)
);

// File: tb/test_rr_logical_fifo.sv
`timescale 1ns/1ps
module test_rr_logical_fifo;

   localparam int LANES  = 4;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 4;
   localparam int CAP    = LANES * DEPTH;
   localparam int CW     = $clog2(CAP + 1);
   localparam int VW     = $clog2(LANES + 1);

   logic                    clk = 1'b0;
   logic                    rst;
   logic [LANES-1:0]        in_valid;
   logic [LANES*DATA_W-1:0] in_data;
   logic                    out_ready;
   logic                    out_valid;
   logic [DATA_W-1:0]       out_data;
   logic                    empty, full;
   logic [CW-1:0]           occupancy;
   logic [VW-1:0]           drop_cnt;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [DATA_W-1:0] sb[$];
   int                m_occ = 0;
   logic [DATA_W-1:0] next_word = 8'h01;
   bit                prev_stall = 0;
   logic [DATA_W-1:0] prev_data = '0;

   always #2.5 clk = ~clk;

   rr_logical_fifo #(.LANES(LANES), .DATA_W(DATA_W), .DEPTH(DEPTH)) i_rr_logical_fifo (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .empty(empty), .full(full), .occupancy(occupancy), .drop_cnt(drop_cnt)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: compares ports with the model inside the current slot
   task automatic monitor(input bit rdy, input int exp_drop);
      chk(int'(occupancy) == m_occ, "R5 occupancy", int'(occupancy), m_occ);
      chk(empty == (m_occ == 0), "R5 empty", int'(empty), int'(m_occ == 0));
      chk(full == (m_occ == CAP), "R5 full", int'(full), int'(m_occ == CAP));
      chk(out_valid == (m_occ > 0), "R4 out_valid", int'(out_valid), int'(m_occ > 0));
      chk(int'(drop_cnt) == exp_drop, "R6 drop_cnt", int'(drop_cnt), exp_drop);
      if (prev_stall && out_valid)
         chk(out_data == prev_data, "R4 hold under stall", int'(out_data), int'(prev_data));
      if (out_valid && rdy && sb.size() > 0) begin
         logic [DATA_W-1:0] e;
         e = sb.pop_front();
         chk(out_data == e, "R2 order", int'(out_data), int'(e));
      end
      prev_stall = out_valid && !rdy;
      prev_data  = out_data;
   endtask

   // driver: one slot of arrivals; pushes expected accepted words
   task automatic slot(input logic [LANES-1:0] mask, input bit rdy);
      int free_sp, nv, acc, k, pop;
      logic [DATA_W-1:0] w [LANES];
      in_valid = mask;
      for (int i = 0; i < LANES; i++) begin
         w[i] = next_word;
         in_data[i*DATA_W +: DATA_W] = next_word;
         next_word = next_word + 8'd1;
      end
      out_ready = rdy;
      free_sp = CAP - m_occ;
      nv = $countones(mask);
      acc = (nv < free_sp) ? nv : free_sp;
      pop = (m_occ > 0 && rdy) ? 1 : 0;
      #1;
      monitor(rdy, nv - acc);
      k = 0;
      for (int i = 0; i < LANES; i++) begin
         if (mask[i]) begin
            if (k < acc) sb.push_back(w[i]);   // R3: idle lanes leave no gap
            k++;
         end
      end
      m_occ = m_occ + acc - pop;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      in_valid = '0;
      out_ready = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      sb.delete();
      m_occ = 0;
      prev_stall = 0;
   endtask

   initial begin
      rst = 1'b1; in_valid = '0; in_data = '0; out_ready = 1'b0;
      @(negedge clk);
      do_reset();
      #1;
      chk(empty == 1'b1, "R1 empty after reset", int'(empty), 1);
      chk(occupancy == '0, "R1 occupancy after reset", int'(occupancy), 0);
      chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
      @(negedge clk);

      // R2: full-width slots with a draining link
      for (int i = 0; i < 6; i++) slot(4'b1111, 1'b1);
      // R2/R3: mixed lane masks and intermittent ready
      for (int i = 0; i < 40; i++) slot(4'((i * 5 + 3) & 15), (i % 3) != 2);
      for (int i = 0; i < 12; i++) slot(4'b0101 << (i % 2), 1'b0);
      // R9: drain and confirm every accepted word came out once
      for (int i = 0; i < 24; i++) slot(4'b0000, 1'b1);
      chk(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
      chk(out_valid == 1'b0, "R9 no extra word", int'(out_valid), 0);

      // R6: fill to capacity, partial drop of a slot's tail
      for (int i = 0; i < 3; i++) slot(4'b1111, 1'b0);
      slot(4'b0111, 1'b0);             // occupancy 15
      slot(4'b1111, 1'b0);             // free 1: one accepted, three dropped
      chk(full == 1'b1, "R5 full at capacity", int'(full), 1);
      // R7: a read in the same slot frees no space for that slot
      slot(4'b1111, 1'b1);             // all four dropped, one removed
      slot(4'b0011, 1'b0);             // free 1: lane 0 in, lane 1 dropped
      // R4: stall keeps data steady
      for (int i = 0; i < 3; i++) slot(4'b0000, 1'b0);
      for (int i = 0; i < 5; i++) slot(4'b0000, 1'b1);

      // R8: reset with data inside discards it
      chk(occupancy != '0, "R8 data present before reset", int'(occupancy), 11);
      do_reset();
      #1;
      chk(empty == 1'b1 && occupancy == '0, "R8 empty after mid reset", int'(occupancy), 0);
      @(negedge clk);
      for (int i = 0; i < 4; i++) slot(4'b1010, 1'b1);
      for (int i = 0; i < 12; i++) slot(4'b0000, 1'b1);
      chk(sb.size() == 0, "R8 fresh sequence delivered", sb.size(), 0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule